// File: doc/BRIEF.md
# Capture Ring Writer

This block is the hardware producer of an audio capture ring held in memory. Sample words from a serial-audio receiver arrive on a valid/ready stream. Each one is stored as one 32-bit word at the next slot of a circular region, through a single-beat memory write port. The hardware owns the producer index and moves it forward after every completed write. Software owns the consumer index and moves it after it has drained data. The writer never advances onto the consumer, so one slot always stays empty and the ring never reaches a full state that would look the same as empty.

Software sets up the block through a small register file. A channel enable starts and stops intake. The base address and the ring size in bytes place the ring in memory. Both indices can be read back. A soft-reset command clears the channel, and a period setting (a length in frames plus an enable bit) makes the block raise an interrupt request pulse each time one full period of words has reached memory. A frame is a compile-time number of channels times four bytes.

Top module: `cap_ring_writer`

## Requirements
- R1: After reset, every register reads zero, `s_ready`, `m_valid` and `irq` are low, and no write is issued.
- R2: A sample accepted on the stream is presented at `m_addr` = base address + producer index (the index as it stood at acceptance), with `m_data` equal to the sample word unchanged (byte 0 of the little-endian word in bits 7:0).
- R3: Each completed memory write (`m_valid` and `m_ready` high) moves the producer index forward by 4, wrapping modulo the ring size (a power of two in bytes, at most 0x200000). The index reads back at offset 0x20.
- R4: `s_ready` is low whenever (producer + 4) mod size equals the consumer index, so the producer never becomes equal to the consumer by advancing; intake resumes once software moves the consumer.
- R5: Software writes the consumer index at offset 0x24 and reads it back there; writes to the producer offset 0x20 have no effect.
- R6: At most one write is in flight: `s_ready` is low while `m_valid` is high, and `m_addr`, `m_data` and `m_valid` hold steady while `m_ready` is low.
- R7: With bit 0 of the period register (offset 0x4C) set, `irq` pulses for one cycle, in the cycle after the write that completes each run of (bits 31:8 of that register) × channels words. With bit 0 clear, no pulse is raised, and a length of zero raises none.
- R8: With the enable (bit 0 at offset 0x14) cleared, `s_ready` stays low. A write already in flight still completes and advances the producer. Both indices keep their values.
- R9: Writing a value with bit 0 set to offset 0x2C clears both indices and the period count. A write that is in flight or accepted at that edge still completes at the memory port but does not move the producer.
- R10: Offset 0x14 reads the enable in bit 0, 0x18 the base address, 0x1C the ring size, and 0x4C the period register as written. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| s_valid | input | 1 | Sample stream valid |
| s_data | input | 32 | Sample word |
| s_ready | output | 1 | Sample stream ready |
| m_valid | output | 1 | Memory write request |
| m_addr | output | ADDR_W | Memory byte address |
| m_data | output | 32 | Memory write data |
| m_ready | input | 1 | Memory accepts the write |
| irq | output | 1 | Period interrupt pulse |

## Verification
The never-full property assumes that software moves the consumer index only forward, to slots already written, and never onto a value the producer is about to reach in the same cycle. It also assumes the ring size and period are whole multiples of the frame and stay fixed while the channel runs. The stimulus writes the consumer only to positions behind the current producer and changes the size and period only while the ring is empty or stopped. The memory side may stall at any time, and the bench drives `m_ready` with an irregular pattern and with long forced stalls, including one that spans a soft reset.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;

  // Register byte offsets decoded by software
  localparam logic [7:0] OFS_ENABLE = 8'h14;
  localparam logic [7:0] OFS_BASE   = 8'h18;
  localparam logic [7:0] OFS_SIZE   = 8'h1C;
  localparam logic [7:0] OFS_PROD   = 8'h20;
  localparam logic [7:0] OFS_CONS   = 8'h24;
  localparam logic [7:0] OFS_SRESET = 8'h2C;
  localparam logic [7:0] OFS_PERIOD = 8'h4C;

  localparam int unsigned WORD_BYTES = 4;

  // Next slot of the ring: step one word, wrap on a power-of-two span
  function automatic logic [31:0] ring_step(input logic [31:0] idx, input logic [31:0] span);
    return (idx + 32'(WORD_BYTES)) & (span - 32'd1);
  endfunction

  // Words that make up one interrupt period
  function automatic logic [31:0] period_words(input logic [23:0] frames, input int unsigned chans);
    return 32'(frames) * 32'(chans);
  endfunction

endpackage

// File: rtl/cap_ring_regs.sv
module cap_ring_regs
  import cap_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 22,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IDX_W-1:0]  prod_idx,
  output logic              chan_en,
  output logic [ADDR_W-1:0] ring_base,
  output logic [IDX_W-1:0]  ring_size,
  output logic [IDX_W-1:0]  cons_idx,
  output logic [23:0]       per_frames,
  output logic              per_irq_en,
  output logic              sreset_evt,
  output logic              cons_wr
);

  logic [31:0] per_cfg_q;

  function automatic logic hit(input logic [7:0] ofs);
    return reg_addr == REG_AW'(ofs);
  endfunction

  assign sreset_evt = reg_we && hit(OFS_SRESET) && reg_wdata[0];
  assign cons_wr    = reg_we && hit(OFS_CONS);
  assign per_frames = per_cfg_q[31:8];
  assign per_irq_en = per_cfg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en   <= 1'b0;
      ring_base <= '0;
      ring_size <= '0;
      cons_idx  <= '0;
      per_cfg_q <= '0;
    end else begin
      if (sreset_evt) cons_idx <= '0;
      if (reg_we) begin
        if (hit(OFS_ENABLE)) chan_en   <= reg_wdata[0];
        if (hit(OFS_BASE))   ring_base <= reg_wdata[ADDR_W-1:0];
        if (hit(OFS_SIZE))   ring_size <= reg_wdata[IDX_W-1:0];
        if (hit(OFS_CONS))   cons_idx  <= reg_wdata[IDX_W-1:0];
        if (hit(OFS_PERIOD)) per_cfg_q <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit(OFS_ENABLE))      reg_rdata = {31'b0, chan_en};
    else if (hit(OFS_BASE))   reg_rdata = 32'(ring_base);
    else if (hit(OFS_SIZE))   reg_rdata = 32'(ring_size);
    else if (hit(OFS_PROD))   reg_rdata = 32'(prod_idx);
    else if (hit(OFS_CONS))   reg_rdata = 32'(cons_idx);
    else if (hit(OFS_PERIOD)) reg_rdata = per_cfg_q;
  end

endmodule

// File: rtl/cap_ring_ptr.sv
module cap_ring_ptr
  import cap_ring_pkg::*;
#(
  parameter int IDX_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ring_size,
  input  logic [IDX_W-1:0] cons_idx,
  input  logic             sreset_evt,
  input  logic             busy,
  input  logic             accept,
  input  logic             wr_done,
  output logic [IDX_W-1:0] prod_idx,
  output logic             has_room,
  output logic             advance_evt
);

  logic             drop_q;
  logic [IDX_W-1:0] next_idx;

  assign next_idx    = IDX_W'(ring_step(32'(prod_idx), 32'(ring_size)));
  assign has_room    = next_idx != cons_idx;
  assign advance_evt = wr_done && !drop_q && !sreset_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_idx <= '0;
      drop_q   <= 1'b0;
    end else if (sreset_evt) begin
      prod_idx <= '0;
      drop_q   <= (busy && !wr_done) || accept;
    end else if (wr_done) begin
      if (drop_q) drop_q   <= 1'b0;
      else        prod_idx <= next_idx;
    end
  end

endmodule

// File: rtl/cap_ring_period.sv
module cap_ring_period
  import cap_ring_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance_evt,
  input  logic        sreset_evt,
  input  logic [23:0] per_frames,
  input  logic        per_irq_en,
  output logic        irq
);

  logic [CNT_W-1:0] words_q;
  logic [CNT_W-1:0] target;
  logic             period_end;

  assign target     = CNT_W'(period_words(per_frames, NUM_CH));
  assign period_end = (target != '0) && ((words_q + 1'b1) >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (sreset_evt) begin
        words_q <= '0;
      end else if (advance_evt) begin
        if (period_end) begin
          words_q <= '0;
          irq     <= per_irq_en;
        end else begin
          words_q <= words_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cap_ring_writer.sv
module cap_ring_writer
  import cap_ring_pkg::*;
#(
  parameter int          ADDR_W         = 32,
  parameter int          REG_AW         = 8,
  parameter int          NUM_CH         = 2,
  parameter int unsigned MAX_RING_BYTES = 32'h0020_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              s_valid,
  input  logic [31:0]       s_data,
  output logic              s_ready,
  output logic              m_valid,
  output logic [ADDR_W-1:0] m_addr,
  output logic [31:0]       m_data,
  input  logic              m_ready,
  output logic              irq
);

  localparam int IDX_W = $clog2(MAX_RING_BYTES) + 1;

  logic              chan_en;
  logic [ADDR_W-1:0] ring_base;
  logic [IDX_W-1:0]  ring_size;
  logic [IDX_W-1:0]  cons_idx;
  logic [IDX_W-1:0]  prod_idx;
  logic [23:0]       per_frames;
  logic              per_irq_en;
  logic              sreset_evt;
  logic              cons_wr;
  logic              has_room;
  logic              advance_evt;
  logic              accept;
  logic              wr_done;

  cap_ring_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .prod_idx(prod_idx),
    .chan_en(chan_en), .ring_base(ring_base), .ring_size(ring_size), .cons_idx(cons_idx),
    .per_frames(per_frames), .per_irq_en(per_irq_en),
    .sreset_evt(sreset_evt), .cons_wr(cons_wr)
  );

  cap_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ring_size(ring_size), .cons_idx(cons_idx), .sreset_evt(sreset_evt),
    .busy(m_valid), .accept(accept), .wr_done(wr_done),
    .prod_idx(prod_idx), .has_room(has_room), .advance_evt(advance_evt)
  );

  cap_ring_period #(.NUM_CH(NUM_CH), .CNT_W(32)) u_period (
    .clk(clk), .rst_n(rst_n),
    .advance_evt(advance_evt), .sreset_evt(sreset_evt),
    .per_frames(per_frames), .per_irq_en(per_irq_en),
    .irq(irq)
  );

  // Single write slot between the stream and the memory port
  assign s_ready = chan_en && !m_valid && has_room;
  assign accept  = s_valid && s_ready;
  assign wr_done = m_valid && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_addr  <= '0;
      m_data  <= '0;
    end else if (accept) begin
      m_valid <= 1'b1;
      m_addr  <= ring_base + ADDR_W'(prod_idx);
      m_data  <= s_data;
    end else if (wr_done) begin
      m_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cap_ring_writer_chk.sv
module cap_ring_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [ADDR_W-1:0] m_addr,
  input logic [31:0]       m_data,
  input logic              irq,
  input logic              chan_en,
  input logic [IDX_W-1:0]  prod_idx,
  input logic [IDX_W-1:0]  cons_idx,
  input logic              advance_evt,
  input logic              sreset_evt,
  input logic              cons_wr
);

  AST_PROD_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) prod_idx[1:0] == 2'b00); // R3

  AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_evt && !cons_wr && !sreset_evt) |=> (prod_idx != cons_idx)); // R4

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) s_ready |-> !m_valid); // R6

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data))); // R6

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R7

  AST_IRQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(advance_evt)); // R7

  AST_DISABLED_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_n) !chan_en |-> !s_ready); // R8

  AST_SRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sreset_evt |=> (prod_idx == '0 && cons_idx == '0)); // R9

endmodule

bind cap_ring_writer cap_ring_writer_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .m_addr(m_addr), .m_data(m_data), .irq(irq), .chan_en(chan_en),
  .prod_idx(prod_idx), .cons_idx(cons_idx), .advance_evt(advance_evt),
  .sreset_evt(sreset_evt), .cons_wr(cons_wr)
);

// File: tb/cap_ring_writer_tb.sv
`timescale 1ns/1ps
module cap_ring_writer_tb;

  localparam int NCH = 2;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic [31:0] s_data;
  logic        s_ready;
  logic        m_valid;
  logic [31:0] m_addr;
  logic [31:0] m_data;
  logic        m_ready = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cap_ring_writer #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data), .m_ready(m_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Source, memory and stall pattern
  int src_n = 0;
  int cyc = 0;
  int irq_cnt = 0;
  bit mr_force = 1'b0;
  bit mr_val = 1'b0;
  logic [31:0] mem [0:15];

  assign s_data = 32'hC0DE_0000 + src_n;

  always @(posedge clk) begin
    if (rst_n && s_valid && s_ready) src_n <= src_n + 1;
    if (m_valid && m_ready) mem[m_addr[5:2]] <= m_data;
    if (rst_n && irq) irq_cnt <= irq_cnt + 1;
    cyc <= cyc + 1;
    m_ready <= mr_force ? mr_val : ((cyc % 3) != 2);
  end

  // Behavioural reference model
  logic [31:0] e_base, e_addr, e_data, e_cfg;
  int e_size, e_prod, e_cons, e_words;
  bit e_en, e_mv, e_drop, e_irq;

  function bit e_ready_f();
    return e_en && !e_mv && (((e_prod + 4) & (e_size - 1)) != e_cons);
  endfunction

  always @(posedge clk or negedge rst_n) begin : ref_model
    bit acc, done, srst;
    int tgt;
    if (!rst_n) begin
      e_base = 0; e_addr = 0; e_data = 0; e_cfg = 0;
      e_size = 0; e_prod = 0; e_cons = 0; e_words = 0;
      e_en = 0; e_mv = 0; e_drop = 0; e_irq = 0;
    end else begin
      acc  = s_valid && e_ready_f();
      done = e_mv && m_ready;
      srst = reg_we && reg_addr == 8'h2C && reg_wdata[0];
      tgt  = int'(e_cfg[31:8]) * NCH;
      if (acc) begin
        e_addr = e_base + e_prod;
        e_data = s_data;
      end
      e_irq = 0;
      if (srst) begin
        e_drop = (e_mv && !done) || acc;
        e_prod = 0; e_cons = 0; e_words = 0;
      end else if (done) begin
        if (e_drop) e_drop = 0;
        else begin
          e_prod = (e_prod + 4) & (e_size - 1);
          if (tgt != 0 && e_words + 1 >= tgt) begin
            e_words = 0;
            e_irq = e_cfg[0];
          end else e_words++;
        end
      end
      if (acc) e_mv = 1;
      else if (done) e_mv = 0;
      if (reg_we) begin
        case (reg_addr)
          8'h14: e_en = reg_wdata[0];
          8'h18: e_base = reg_wdata;
          8'h1C: e_size = int'(reg_wdata[21:0]);
          8'h24: e_cons = int'(reg_wdata[21:0]);
          8'h4C: e_cfg = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 s_ready", {31'b0, s_ready}, {31'b0, e_ready_f()});
      chk("R6 m_valid", {31'b0, m_valid}, {31'b0, e_mv});
      if (e_mv) begin
        chk("R2 m_addr", m_addr, e_addr);
        chk("R2 m_data", m_data, e_data);
      end
      chk("R7 irq", {31'b0, irq}, {31'b0, e_irq});
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk);
    reg_we <= 1'b1; reg_addr <= a; reg_wdata <= d;
    @(posedge clk);
    reg_we <= 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk);
    reg_addr <= a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    summary();
  end

  initial begin : main
    logic [31:0] rd, p1;
    int irq_snap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 s_ready at reset", {31'b0, s_ready}, 32'd0);
    chk("R1 m_valid at reset", {31'b0, m_valid}, 32'd0);
    chk("R1 irq at reset", {31'b0, irq}, 32'd0);
    rst_n = 1'b1;
    foreach (u_regs_ofs[i]) begin
      reg_read(u_regs_ofs[i], rd);
      chk("R1 register reset value", rd, 32'd0);
    end

    // Configure: 64-byte ring, period 2 frames (4 words), interrupt on
    reg_write(8'h18, BASE);
    reg_write(8'h1C, 32'd64);
    reg_write(8'h4C, (32'd2 << 8) | 32'd1);
    reg_write(8'h14, 32'd1);
    reg_read(8'h14, rd); chk("R10 enable readback", rd, 32'd1);
    reg_read(8'h18, rd); chk("R10 base readback", rd, BASE);
    reg_read(8'h1C, rd); chk("R10 size readback", rd, 32'd64);
    reg_read(8'h4C, rd); chk("R10 period readback", rd, 32'h0000_0201);
    reg_read(8'h30, rd); chk("R10 unmapped reads zero", rd, 32'd0);

    // Fill until one slot short of the consumer
    @(posedge clk); s_valid <= 1'b1;
    repeat (120) @(posedge clk);
    reg_read(8'h20, rd); chk("R4 producer stalls one word before consumer", rd, 32'd60);
    @(negedge clk); chk("R4 ready low when ring has one free slot", {31'b0, s_ready}, 32'd0);
    chk("R2 first word in memory", mem[0], 32'hC0DE_0000);
    chk("R2 word 14 in memory", mem[14], 32'hC0DE_000E);
    chk("R7 three periods raised", irq_cnt, 32'd3);

    // Consumer moves: writer resumes and wraps
    reg_write(8'h24, 32'd32);
    repeat (80) @(posedge clk);
    reg_read(8'h20, rd); chk("R3 producer wraps and stops at 28", rd, 32'd28);
    @(negedge clk);
    chk("R3 word at last slot", mem[15], 32'hC0DE_000F);
    chk("R3 word after wrap at offset 0", mem[0], 32'hC0DE_0010);
    chk("R3 word at offset 24", mem[6], 32'hC0DE_0016);
    chk("R7 five periods raised", irq_cnt, 32'd5);

    // Producer index is not writable by software
    reg_write(8'h20, 32'h10);
    reg_read(8'h20, rd); chk("R5 producer write ignored", rd, 32'd28);
    reg_read(8'h24, rd); chk("R5 consumer readback", rd, 32'd32);

    // Disable while running
    reg_write(8'h24, 32'd24);
    repeat (4) @(posedge clk);
    reg_write(8'h14, 32'd0);
    repeat (12) @(posedge clk);
    reg_read(8'h20, p1); chk("R8 producer matches model after disable", p1, 32'(e_prod));
    repeat (20) @(posedge clk);
    reg_read(8'h20, rd); chk("R8 producer frozen while disabled", rd, p1);
    @(negedge clk); chk("R8 ready low while disabled", {31'b0, s_ready}, 32'd0);
    reg_read(8'h24, rd); chk("R8 consumer kept while disabled", rd, 32'd24);

    // Soft reset with a write held at the memory port
    @(posedge clk); s_valid <= 1'b0; mr_force <= 1'b1; mr_val <= 1'b0;
    reg_write(8'h14, 32'd1);
    @(posedge clk); s_valid <= 1'b1;
    repeat (3) @(posedge clk);
    s_valid <= 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); chk("R6 write held while memory stalls", {31'b0, m_valid}, 32'd1);
    reg_write(8'h2C, 32'd1);
    reg_read(8'h20, rd); chk("R9 producer cleared", rd, 32'd0);
    reg_read(8'h24, rd); chk("R9 consumer cleared", rd, 32'd0);
    @(posedge clk); mr_val <= 1'b1;
    repeat (6) @(posedge clk);
    reg_read(8'h20, rd); chk("R9 held write does not advance", rd, 32'd0);
    @(negedge clk); chk("R9 held write completed", {31'b0, m_valid}, 32'd0);

    // Interrupt disabled: counting continues, no pulses
    reg_write(8'h4C, 32'd2 << 8);
    @(posedge clk); mr_force <= 1'b0;
    @(negedge clk); irq_snap = irq_cnt;
    @(posedge clk); s_valid <= 1'b1;
    repeat (100) @(posedge clk);
    reg_read(8'h20, rd); chk("R4 refill stops at 60", rd, 32'd60);
    chk("R7 no pulse with interrupt bit clear", irq_cnt, irq_snap);

    @(posedge clk); s_valid <= 1'b0;
    repeat (4) @(posedge clk);
    summary();
  end

  logic [7:0] u_regs_ofs [0:5] = '{8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h4C};

endmodule